// File: doc/BRIEF.md
# Interval Timer with Register Bank

A down-counting interval timer reached through a word-addressed 32-bit register port. Software loads a 32-bit period as two 16-bit halves, starts the counter, and is told of expiry through a sticky timeout flag and an interrupt line gated by an enable bit. The counter reloads its period on expiry. In continuous mode it runs on. In one-shot mode it halts.

A snapshot register freezes the live count on a write, so software can read both halves of one consistent value. Writing either period half stops the counter and loads the new period at once. Any write to the status word drops the timeout flag.

Top module: `interval_timer`

## Requirements
- R1: After reset, status and control read zero, both period halves read 0xFFFF, both snapshot halves read zero, irq_o is low, and the counter is stopped holding all ones.
- R2: Word offsets are 0 status, 1 control, 2 period bits 15:0, 3 period bits 31:16, 4 snapshot bits 15:0, 5 snapshot bits 31:16. Control bit 0 is the interrupt enable and bit 1 is continuous mode; both read back. Control bits 2 and 3 read zero.
- R3: Writing control bit 2 (start) sets the running state and writing bit 3 (stop) clears it; both are strobes, and when both are set in one write the counter stops.
- R4: A running counter decreases by one each cycle; a stopped counter holds its value.
- R5: When the counter is running and at zero, status bit 0 (timeout) is set at the next clock edge. Status bit 1 reads the running state.
- R6: In one-shot mode (control bit 1 = 0), the counter reloads the period on timeout and stops.
- R7: In continuous mode (control bit 1 = 1), the counter reloads the period on timeout and keeps running.
- R8: A write to offset 2 or 3 stops the counter and loads it with the full 32-bit period that includes the new half.
- R9: Any write to offset 0 clears the timeout flag, whatever the data. A timeout arriving in the same cycle leaves the flag set.
- R10: A write to offset 4 or 5 captures the count held before that edge. Offsets 4 and 5 then read its low and high halves.
- R11: irq_o is high exactly when the timeout flag and control bit 0 are both set.
- R12: rdata_o is registered. It updates only on an edge where rd_en_i is high and shows the register state before that edge. Otherwise it holds. Offsets 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Word offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Timeout interrupt |

## Verification
The timeout set and a software clear of the flag can fall on the same edge. The bench programs a period of three and starts the counter. It then waits until the count reaches zero and issues the status write exactly on the expiry edge. It expects a later status read to show the flag still set. A plain clear that follows must drop the flag. A period write on a running counter also competes with the decrement. This is judged through a snapshot showing the freshly loaded period with the counter stopped.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS  = 3'd0,
    REG_CTRL    = 3'd1,
    REG_PER_LO  = 3'd2,
    REG_PER_HI  = 3'd3,
    REG_SNAP_LO = 3'd4,
    REG_SNAP_HI = 3'd5
  } reg_sel_e;

  localparam int CTRL_IRQ_EN = 0;
  localparam int CTRL_CONT   = 1;
  localparam int CTRL_START  = 2;
  localparam int CTRL_STOP   = 3;

  localparam int ST_TMO = 0;
  localparam int ST_RUN = 1;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             load_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             cont_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             timeout_o
);
  logic [CNT_W-1:0] count_q;
  logic             run_q;

  assign timeout_o = run_q && (count_q == '0);
  assign count_o   = count_q;
  assign running_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '1;
      run_q   <= 1'b0;
    end else begin
      if (load_i || timeout_o) count_q <= period_i;
      else if (run_q)          count_q <= count_q - 1'b1;

      if (load_i || stop_i)         run_q <= 1'b0;
      else if (start_i)             run_q <= 1'b1;
      else if (timeout_o && !cont_i) run_q <= 1'b0;
    end
  end

  a_r4_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && count_q != '0 && !load_i |=> count_q == $past(count_q) - 1'b1);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !load_i && !start_i |=> $stable(count_q));
  a_r3_stop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_q);
  a_r6_oneshot_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !cont_i && !start_i |=> !run_q && count_q == $past(period_i));
  a_r7_cont_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && cont_i && !load_i && !stop_i |=> run_q && count_q == $past(period_i));
  a_r8_period_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !run_q && count_q == $past(period_i));
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import interval_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int HALVES = 2,
  localparam int CNT_W  = HALVES * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              running_i,
  input  logic              timeout_i,
  output logic [CNT_W-1:0]  period_o,
  output logic              load_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              cont_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CNT_W-1:0]  per_q, per_d, snap_q;
  logic [HALVES-1:0] per_hit;
  logic              flag_q, irq_en_q, cont_q;
  logic              st_wr, ctrl_wr, snap_wr;
  logic [DATA_W-1:0] rd_mux;

  assign st_wr   = wr_en_i && addr_i == REG_STATUS;
  assign ctrl_wr = wr_en_i && addr_i == REG_CTRL;
  assign snap_wr = wr_en_i && (addr_i == REG_SNAP_LO || addr_i == REG_SNAP_HI);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign per_hit[h] = wr_en_i && addr_i == ADDR_W'(int'(REG_PER_LO) + h);
    assign per_d[h*HALF_W +: HALF_W] = per_hit[h] ? wdata_i[HALF_W-1:0]
                                                  : per_q[h*HALF_W +: HALF_W];
  end

  assign period_o = per_d;
  assign load_o   = |per_hit;
  // stop beats start inside the counter
  assign start_o  = ctrl_wr && wdata_i[CTRL_START];
  assign stop_o   = ctrl_wr && wdata_i[CTRL_STOP];
  assign cont_o   = cont_q;
  assign irq_o    = flag_q && irq_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q    <= '1;
      snap_q   <= '0;
      flag_q   <= 1'b0;
      irq_en_q <= 1'b0;
      cont_q   <= 1'b0;
    end else begin
      per_q <= per_d;
      if (snap_wr) snap_q <= count_i;
      if (timeout_i)  flag_q <= 1'b1;
      else if (st_wr) flag_q <= 1'b0;
      if (ctrl_wr) begin
        irq_en_q <= wdata_i[CTRL_IRQ_EN];
        cont_q   <= wdata_i[CTRL_CONT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      REG_STATUS: begin
        rd_mux[ST_TMO] = flag_q;
        rd_mux[ST_RUN] = running_i;
      end
      REG_CTRL: begin
        rd_mux[CTRL_IRQ_EN] = irq_en_q;
        rd_mux[CTRL_CONT]   = cont_q;
      end
      REG_PER_LO:  rd_mux = DATA_W'(per_q[0 +: HALF_W]);
      REG_PER_HI:  rd_mux = DATA_W'(per_q[HALF_W +: HALF_W]);
      REG_SNAP_LO: rd_mux = DATA_W'(snap_q[0 +: HALF_W]);
      REG_SNAP_HI: rd_mux = DATA_W'(snap_q[HALF_W +: HALF_W]);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  a_r5_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> flag_q);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr && !timeout_i |=> !flag_q);
  a_r10_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_wr |=> snap_q == $past(count_i));
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] period, count;
  logic load, start, stop, cont, running, timeout;

  tmr_regfile #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i,
    .count_i(count), .running_i(running), .timeout_i(timeout),
    .period_o(period), .load_o(load), .start_o(start), .stop_o(stop),
    .cont_o(cont), .irq_o, .rdata_o
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .period_i(period), .load_i(load), .start_i(start),
    .stop_i(stop), .cont_i(cont), .count_o(count), .running_o(running),
    .timeout_o(timeout)
  );

  a_r11_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout && !(wr_en_i && addr_i == REG_CTRL) && $past(rst_ni) |=>
      irq_o == $past(u_regs.irq_en_q));
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_ST = 3'd0, A_CTRL = 3'd1, A_PLO = 3'd2,
                         A_PHI = 3'd3, A_SLO = 3'd4, A_SHI = 3'd5;

  typedef struct packed {
    logic [31:0] per;
    logic        cont;
    logic [7:0]  wait_n;
    logic [31:0] exp_st;
  } vec_t;

  // status read after wait_n edges following the start edge
  localparam vec_t VECS [5] = '{
    '{32'd3,  1'b0, 8'd3, 32'h2},
    '{32'd3,  1'b0, 8'd4, 32'h1},
    '{32'd5,  1'b1, 8'd6, 32'h3},
    '{32'd0,  1'b0, 8'd1, 32'h1},
    '{32'd10, 1'b1, 8'd2, 32'h2}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, d, a0;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer u_interval_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge, consumes exactly one rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    addr = a; wdata = v; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(A_ST, d);   chk("R1 status", d, 0);
    rd(A_CTRL, d); chk("R1 control", d, 0);
    rd(A_PLO, d);  chk("R1 period lo", d, 32'hFFFF);
    rd(A_PHI, d);  chk("R1 period hi", d, 32'hFFFF);
    rd(A_SLO, d);  chk("R1 snap lo", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    wr(A_SLO, 0);
    rd(A_SHI, d);  chk("R1 R4 stopped count all ones", d, 32'hFFFF);

    // R5 R6 R7 table walk
    foreach (VECS[i]) begin
      wr(A_PLO, {16'd0, VECS[i].per[15:0]});
      wr(A_PHI, {16'd0, VECS[i].per[31:16]});
      wr(A_ST, 32'hFFFF_FFFF);
      wr(A_CTRL, 32'h4 | {30'd0, VECS[i].cont, 1'b0});
      idle(int'(VECS[i].wait_n));
      rd(A_ST, d);
      chk($sformatf("R5 R6 R7 vector %0d status", i), d, VECS[i].exp_st);
    end

    // R7 reload value in continuous mode
    wr(A_PLO, 5); wr(A_PHI, 0); wr(A_ST, 0);
    wr(A_CTRL, 32'h6);
    idle(6);
    wr(A_SNAP_LO_or(A_SLO), 0);
    rd(A_SLO, d); chk("R7 reloaded count", d, 5);
    rd(A_ST, d);  chk("R7 still running", d & 32'h2, 32'h2);
    wr(A_CTRL, 32'h8);

    // R4 decrement, R10 capture while running
    wr(A_PLO, 100); wr(A_PHI, 0);
    wr(A_CTRL, 32'h4);
    idle(10);
    wr(A_SHI, 0);
    rd(A_SLO, d); chk("R4 R10 snap lo", d, 90);
    rd(A_SHI, d); chk("R10 snap hi", d, 0);

    // R8 period write on running counter
    wr(A_PHI, 1);
    wr(A_SLO, 0);
    rd(A_SHI, d); chk("R8 loaded hi", d, 1);
    rd(A_SLO, d); chk("R8 loaded lo", d, 100);
    wr(A_ST, 0);
    rd(A_ST, d);  chk("R8 stopped", d, 0);
    rd(A_PHI, d); chk("R2 period hi readback", d, 1);

    // R3 start / stop / both
    wr(A_CTRL, 32'h4);
    rd(A_ST, d); chk("R3 start", d, 32'h2);
    wr(A_CTRL, 32'hC);
    rd(A_ST, d); chk("R3 stop wins", d, 0);
    wr(A_SLO, 0); rd(A_SLO, a0);
    idle(3);
    wr(A_SLO, 0); rd(A_SLO, d);
    chk("R4 stopped count holds", d, a0);
    wr(A_CTRL, 32'hF);
    rd(A_CTRL, d); chk("R2 control readback", d, 32'h3);
    rd(A_ST, d);   chk("R3 both bits stop", d, 0);
    wr(A_CTRL, 0);

    // R9 set beats clear on the same edge
    wr(A_PLO, 3); wr(A_PHI, 0); wr(A_ST, 0);
    wr(A_CTRL, 32'h4);
    idle(3);
    wr(A_ST, 0);
    rd(A_ST, d); chk("R9 set wins over clear", d, 32'h1);
    wr(A_ST, 32'h1234);
    rd(A_ST, d); chk("R9 clear any data", d, 0);

    // R11 interrupt gating
    wr(A_PLO, 2);
    wr(A_CTRL, 32'h5);
    idle(2);
    chk("R11 irq before timeout", {31'd0, irq}, 0);
    idle(1);
    chk("R11 irq on timeout", {31'd0, irq}, 1);
    wr(A_CTRL, 0);
    chk("R11 irq masked", {31'd0, irq}, 0);
    wr(A_CTRL, 1);
    chk("R11 irq unmasked", {31'd0, irq}, 1);
    wr(A_ST, 0);
    chk("R11 irq after clear", {31'd0, irq}, 0);

    // R12 unmapped and hold
    rd(3'd6, d); chk("R12 unmapped", d, 0);
    rd(A_CTRL, d); chk("R12 control", d, 1);
    wr(A_CTRL, 0);
    idle(2);
    chk("R12 rdata holds", rdata, 1);

    done = 1;
    finish_run();
  end

  function automatic logic [2:0] A_SNAP_LO_or(input logic [2:0] a);
    return a;
  endfunction
endmodule